// File: doc/BRIEF.md
# Maskable Interrupt Dispatcher

This block watches three level-sensitive interrupt sources: an external request, a critical request and a machine-check request. Each source first passes through a two-flop synchronizer. It is then gated by its own enable bit, taken from the processor's machine state. When a qualified request is present, the block raises a dispatch strobe. The strobe carries the index of the vector-offset register that the core uses to find the handler. The strobe and its index hold until the core acknowledges them.

A machine check that arrives while its enable is clear is never dispatched. It drives the block into a checkstop state that only reset releases, and no dispatch of any kind happens after that. Every machine-check event also raises a syndrome-valid flag. The flag tells the rest of the core that the syndrome register has fresh content.

The controller has three named states. IDLE waits for a request. PEND holds a dispatch until it is acknowledged. STOP is the checkstop trap. The transitions are:
- IDLE->PEND: a qualified request was selected.
- IDLE->STOP: a machine check arrived with its enable clear.
- PEND->IDLE: acknowledge.
- STOP has no exit; only reset leaves it.
- The controller stays in the same state in every other case.

Top module: `irq_dispatch_top`

## Requirements
- R1: After reset, `disp_valid_o`, `checkstop_o` and `syndrome_valid_o` are all 0.
- R2: A synchronized external request with `ext_en_i`=1 dispatches with `disp_vec_o`=4.
- R3: A synchronized critical request with `crit_en_i`=1 dispatches with `disp_vec_o`=0.
- R4: While `crit_en_i`=0, the critical input produces no dispatch, whatever its level.
- R5: A machine check with `mchk_en_i`=1 dispatches with `disp_vec_o`=1.
- R6: A machine check with `mchk_en_i`=0, seen in IDLE, sets `checkstop_o`. The flag stays set until reset, and while it is set `disp_valid_o` stays 0.
- R7: When several qualified requests are present together, the machine check wins (vector 1), then critical (vector 0), then external (vector 4).
- R8: While `disp_valid_o`=1 and `disp_ack_i`=0, `disp_vec_o` and `disp_valid_o` hold. A newer request does not replace a pending one. An acknowledge returns the block to IDLE on the next cycle.
- R9: An input change is first visible to the dispatch logic after two flops. A request driven between edges shows on `disp_valid_o` after the third following rising edge.
- R10: `syndrome_valid_o` sets on every machine-check event, whether dispatched or checkstopped. It clears when a pending dispatch is acknowledged, and it stays set in checkstop.
- R11: While `ext_en_i`=0, the external input produces no dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | 1 | External interrupt request, level |
| crit_irq_i | input | 1 | Critical interrupt request, level |
| mchk_irq_i | input | 1 | Machine-check request, level |
| ext_en_i | input | 1 | External enable from machine state |
| crit_en_i | input | 1 | Critical enable from machine state |
| mchk_en_i | input | 1 | Machine-check enable from machine state |
| disp_ack_i | input | 1 | Core accepts the pending dispatch |
| disp_valid_o | output | 1 | Dispatch pending |
| disp_vec_o | output | VEC_W | Vector-offset register index |
| checkstop_o | output | 1 | Sticky checkstop |
| syndrome_valid_o | output | 1 | Machine-check syndrome has fresh content |

## Verification
The bench raises all three sources in the same cycle to confirm the priority order. A design with the wrong order would report vector 0 or 4 where vector 1 belongs. It raises new requests while a dispatch is pending. A design that does not hold would change the index before acknowledge. It holds the critical line high with its enable clear to catch leaky gating. It also drives requests after a checkstop, because a design whose checkstop is not sticky would dispatch them. The two-flop latency is measured edge by edge, and a missing synchronizer stage would show the strobe one cycle early.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_STOP = 2'd2
    } disp_state_e;

    // Source positions in the synchronized request vector
    localparam int SRC_EXT  = 0;
    localparam int SRC_CRIT = 1;
    localparam int SRC_MCHK = 2;
    localparam int NUM_SRC  = 3;

    // Vector-offset register indices per source
    localparam int VEC_EXT  = 4;
    localparam int VEC_CRIT = 0;
    localparam int VEC_MCHK = 1;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[LAST];

endmodule

// File: rtl/irq_qualify.sv
module irq_qualify
    import irq_dispatch_pkg::*;
#(
    parameter int VEC_W = 4
) (
    input  logic [NUM_SRC-1:0] req_sync_i,
    input  logic               ext_en_i,
    input  logic               crit_en_i,
    input  logic               mchk_en_i,
    output logic               take_o,
    output logic               is_mchk_o,
    output logic               stop_o,
    output logic [VEC_W-1:0]   vec_o
);

    logic ext_ok, crit_ok, mchk_ok;

    always_comb begin
        ext_ok  = req_sync_i[SRC_EXT]  & ext_en_i;
        crit_ok = req_sync_i[SRC_CRIT] & crit_en_i;
        mchk_ok = req_sync_i[SRC_MCHK] & mchk_en_i;
        stop_o  = req_sync_i[SRC_MCHK] & ~mchk_en_i;
    end

    always_comb begin
        take_o    = 1'b0;
        is_mchk_o = 1'b0;
        vec_o     = '0;
        if (mchk_ok) begin
            take_o    = 1'b1;
            is_mchk_o = 1'b1;
            vec_o     = VEC_W'(VEC_MCHK);
        end else if (crit_ok) begin
            take_o = 1'b1;
            vec_o  = VEC_W'(VEC_CRIT);
        end else if (ext_ok) begin
            take_o = 1'b1;
            vec_o  = VEC_W'(VEC_EXT);
        end
    end

endmodule

// File: rtl/irq_dispatch_fsm.sv
module irq_dispatch_fsm
    import irq_dispatch_pkg::*;
#(
    parameter int VEC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic             is_mchk_i,
    input  logic             stop_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             ack_i,
    output logic             valid_o,
    output logic [VEC_W-1:0] vec_o,
    output logic             checkstop_o,
    output logic             syndrome_o
);

    disp_state_e      state_q, state_d;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic             syn_q, syn_d;

    always_comb begin
        state_d = state_q;
        vec_d   = vec_q;
        syn_d   = syn_q;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_i) begin
                    state_d = ST_STOP;
                    syn_d   = 1'b1;
                end else if (take_i) begin
                    state_d = ST_PEND;
                    vec_d   = vec_i;
                    if (is_mchk_i) syn_d = 1'b1;
                end
            end
            ST_PEND: begin
                if (ack_i) begin
                    state_d = ST_IDLE;
                    syn_d   = 1'b0;
                end
            end
            ST_STOP: begin
                state_d = ST_STOP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
            syn_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vec_q   <= vec_d;
            syn_q   <= syn_d;
        end
    end

    always_comb begin
        valid_o     = (state_q == ST_PEND);
        checkstop_o = (state_q == ST_STOP);
        vec_o       = vec_q;
        syndrome_o  = syn_q;
    end

    // R8
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> (valid_o && $stable(vec_o)));

    // R8
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ack_i) |=> !valid_o);

    // R6
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |=> checkstop_o);

    // R6
    stop_no_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |-> !valid_o);

    // R10
    stop_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        checkstop_o |-> syndrome_o);

    // R5
    mchk_syn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && vec_o == VEC_W'(VEC_MCHK)) |-> syndrome_o);

endmodule

// File: rtl/irq_dispatch_top.sv
module irq_dispatch_top
    import irq_dispatch_pkg::*;
#(
    parameter int VEC_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_irq_i,
    input  logic             crit_irq_i,
    input  logic             mchk_irq_i,
    input  logic             ext_en_i,
    input  logic             crit_en_i,
    input  logic             mchk_en_i,
    input  logic             disp_ack_i,
    output logic             disp_valid_o,
    output logic [VEC_W-1:0] disp_vec_o,
    output logic             checkstop_o,
    output logic             syndrome_valid_o
);

    logic [NUM_SRC-1:0] req_raw, req_sync;
    logic               take, is_mchk, stop;
    logic [VEC_W-1:0]   sel_vec;

    always_comb begin
        req_raw           = '0;
        req_raw[SRC_EXT]  = ext_irq_i;
        req_raw[SRC_CRIT] = crit_irq_i;
        req_raw[SRC_MCHK] = mchk_irq_i;
    end

    irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (req_raw),
        .sync_o  (req_sync)
    );

    irq_qualify #(.VEC_W(VEC_W)) u_qual (
        .req_sync_i (req_sync),
        .ext_en_i   (ext_en_i),
        .crit_en_i  (crit_en_i),
        .mchk_en_i  (mchk_en_i),
        .take_o     (take),
        .is_mchk_o  (is_mchk),
        .stop_o     (stop),
        .vec_o      (sel_vec)
    );

    irq_dispatch_fsm #(.VEC_W(VEC_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .is_mchk_i   (is_mchk),
        .stop_i      (stop),
        .vec_i       (sel_vec),
        .ack_i       (disp_ack_i),
        .valid_o     (disp_valid_o),
        .vec_o       (disp_vec_o),
        .checkstop_o (checkstop_o),
        .syndrome_o  (syndrome_valid_o)
    );

    // R4
    crit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(disp_valid_o) && disp_vec_o == VEC_W'(VEC_CRIT)) |-> $past(crit_en_i));

    // R11
    ext_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(disp_valid_o) && disp_vec_o == VEC_W'(VEC_EXT)) |-> $past(ext_en_i));

endmodule

// File: tb/tb_irq_dispatch_top.sv
module tb_irq_dispatch_top;

    localparam int CLK_PERIOD = 10;
    localparam int VEC_W      = 4;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_irq = 0, crit_irq = 0, mchk_irq = 0;
    logic ext_en = 0, crit_en = 0, mchk_en = 0;
    logic ack = 0;
    logic             valid;
    logic [VEC_W-1:0] vec;
    logic             cstop;
    logic             syn;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dispatch_top #(.VEC_W(VEC_W)) dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .ext_irq_i        (ext_irq),
        .crit_irq_i       (crit_irq),
        .mchk_irq_i       (mchk_irq),
        .ext_en_i         (ext_en),
        .crit_en_i        (crit_en),
        .mchk_en_i        (mchk_en),
        .disp_ack_i       (ack),
        .disp_valid_o     (valid),
        .disp_vec_o       (vec),
        .checkstop_o      (cstop),
        .syndrome_valid_o (syn)
    );

    // Behavioural reference: 0 idle, 1 pending, 2 checkstop
    int m_mode = 0;
    int m_vec  = 0;
    bit m_syn  = 0;
    bit m_p1[3];
    bit m_p2[3];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_vec = 0; m_syn = 0;
            for (int i = 0; i < 3; i++) begin m_p1[i] = 0; m_p2[i] = 0; end
        end else begin
            if (m_mode == 0) begin
                if (m_p2[2] && !mchk_en) begin m_mode = 2; m_syn = 1; end
                else if (m_p2[2])            begin m_mode = 1; m_vec = 1; m_syn = 1; end
                else if (m_p2[1] && crit_en) begin m_mode = 1; m_vec = 0; end
                else if (m_p2[0] && ext_en)  begin m_mode = 1; m_vec = 4; end
            end else if (m_mode == 1) begin
                if (ack) begin m_mode = 0; m_syn = 0; end
            end
            for (int i = 0; i < 3; i++) m_p2[i] = m_p1[i];
            m_p1[0] = ext_irq; m_p1[1] = crit_irq; m_p1[2] = mchk_irq;
        end
    end

    task automatic chk(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R8 valid", int'(valid), (m_mode == 1) ? 1 : 0);
            if (m_mode == 1) chk("R7 vector", int'(vec), m_vec);
            chk("R6 checkstop", int'(cstop), (m_mode == 2) ? 1 : 0);
            chk("R10 syndrome", int'(syn), int'(m_syn));
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        cyc(2); rst_n = 1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WATCHDOG && !done) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        cyc(3);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 valid", int'(valid), 0);
        chk("R1 checkstop", int'(cstop), 0);
        chk("R1 syndrome", int'(syn), 0);

        // R9 latency, R2 external vector
        ext_en = 1; crit_en = 1; mchk_en = 1;
        ext_irq = 1;
        @(negedge clk); chk("R9 edge1", int'(valid), 0);
        @(negedge clk); chk("R9 edge2", int'(valid), 0);
        @(negedge clk); chk("R9 edge3", int'(valid), 1);
        chk("R2 ext vector", int'(vec), 4);

        // R8 hold while a critical request arrives
        crit_irq = 1;
        cyc(6);
        chk("R8 still pending", int'(valid), 1);
        chk("R8 vector held", int'(vec), 4);
        ext_irq = 0;
        do_ack();
        chk("R8 released", int'(valid), 0);
        cyc(1);
        chk("R3 crit vector", int'(vec), 0);
        chk("R3 crit valid", int'(valid), 1);
        crit_irq = 0;
        do_ack();
        cyc(4);

        // R4 critical ignored while disabled
        crit_en = 0; crit_irq = 1;
        cyc(10);
        chk("R4 no crit dispatch", int'(valid), 0);
        crit_irq = 0;
        cyc(4);
        crit_en = 1;
        cyc(3);
        chk("R4 no late dispatch", int'(valid), 0);

        // R11 external ignored while disabled
        ext_en = 0; ext_irq = 1;
        cyc(8);
        chk("R11 no ext dispatch", int'(valid), 0);
        ext_irq = 0;
        cyc(4);
        ext_en = 1;

        // R7 priority with all three, R5 machine check vector
        ext_irq = 1; crit_irq = 1; mchk_irq = 1;
        cyc(3);
        chk("R5 mchk vector", int'(vec), 1);
        chk("R10 syndrome set", int'(syn), 1);
        mchk_irq = 0;
        do_ack();
        chk("R10 syndrome cleared", int'(syn), 0);
        cyc(1);
        chk("R7 crit over ext", int'(vec), 0);
        crit_irq = 0;
        do_ack();
        cyc(1);
        chk("R7 ext last", int'(vec), 4);
        ext_irq = 0;
        do_ack();
        cyc(4);

        // R6 checkstop with machine check disabled
        mchk_en = 0; mchk_irq = 1;
        cyc(3);
        chk("R6 checkstop set", int'(cstop), 1);
        chk("R10 syndrome in stop", int'(syn), 1);
        mchk_irq = 0; ext_irq = 1; crit_irq = 1; mchk_en = 1;
        cyc(10);
        chk("R6 sticky", int'(cstop), 1);
        chk("R6 no dispatch", int'(valid), 0);
        ext_irq = 0; crit_irq = 0;
        do_reset();
        @(negedge clk);
        chk("R1 checkstop cleared", int'(cstop), 0);
        chk("R1 syndrome cleared", int'(syn), 0);

        // Ack while idle has no effect, then a back-to-back external run
        do_ack();
        chk("R8 stray ack", int'(valid), 0);
        for (int k = 0; k < 20; k++) begin
            ext_irq = (k % 3 != 0);
            crit_irq = (k % 5 == 0);
            @(negedge clk);
            if (valid && (k % 2 == 0)) ack = 1; else ack = 0;
        end
        ext_irq = 0; crit_irq = 0; ack = 0;
        cyc(8);
        while (valid) do_ack();
        cyc(4);
        finish_run();
    end

endmodule